// File: doc/BRIEF.md
# I2C Controller Register Front End with Command, Transmit and Receive Queues

This block sits between an APB bus and a serial I2C engine. Software programs the engine through a small register map. A write to the command register queues one command entry. A write to the data register queues one transmit byte together with its end-of-block marker. A read of the data register takes one received byte from the receive queue. The engine is not part of the block. It is represented by three ready/valid streams: commands leave the block, transmit bytes leave the block, and received bytes enter it. It also supplies four live status inputs and receives the clock divider value.

The block combines queue levels, sticky overflow indications and engine status into a 12-bit raw flag word. A mask register selects which flags can raise the single interrupt output. Each APB transfer finishes in its access phase with no wait states.

Top module: `i2c_apb_frontend`

## Requirements
- R1: Every APB transfer completes with no wait state and `pready` is always 1. Reads of addresses outside the map return 0. Reads of the command register (0x0004) and of the clear register (0xFF0C) also return 0.
- R2: A write to 0x0004 queues an entry `cmd_data` = {stop=pwdata[12], block-write=pwdata[11], write=pwdata[10], read=pwdata[9], start=pwdata[8], address=pwdata[6:0]}, packed from bit 11 down to bit 0. Entries leave in order on `cmd_valid`/`cmd_ready`. A write with both pwdata[9] and pwdata[10] set queues nothing.
- R3: A write to 0x0008 queues the byte pwdata[7:0] together with the last marker pwdata[9]. These leave in order on `wr_data`/`wr_last` under `wr_valid`/`wr_ready`.
- R4: A read of 0x0008 while the receive queue holds data returns the oldest byte in bits 7:0, 1 in bit 8 and 0 in bit 9, and removes that byte from the queue. When the receive queue is empty the read returns 0 and removes nothing.
- R5: `rd_ready` is 1 exactly when the receive queue is not full. A byte is accepted on a cycle where both `rd_valid` and `rd_ready` are 1.
- R6: The raw flags, read at 0xFF08, are: bit 0 busy, bit 1 bus owned, bit 2 bus active, bit 3 missed acknowledge, bit 4 command queue empty, bit 5 command queue full, bit 6 command overflow, bit 7 transmit queue empty, bit 8 transmit queue full, bit 9 transmit overflow, bit 10 receive queue empty, bit 11 receive queue full. All flags except bits 6 and 9 follow their source directly.
- R7: Bit 6 sets when a command write that would be queued meets a full command queue. Bit 9 sets when a data write meets a full transmit queue. Each stays set until a write to 0xFF0C has a 1 in its bit position.
- R8: The mask at 0xFF00 is read/write. 0xFF04 reads the raw flags ANDed with the mask, and writes to it have no effect. `irq` is the OR of those masked bits.
- R9: `prescale` resets to DEFAULT_PRESCALE (1), and 0x000C reads it back. A write to 0x000C loads pwdata[PRESCALE_W-1:0], except when FIXED_PRESCALE is nonzero; the value then stays at the default.
- R10: After reset all queues are empty, the mask is 0 and both overflow flags are 0, so the raw flags read 0x490.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| cmd_valid | output | 1 | Command queue holds an entry |
| cmd_ready | input | 1 | Engine takes the head command |
| cmd_data | output | 12 | Head command entry |
| wr_valid | output | 1 | Transmit queue holds a byte |
| wr_ready | input | 1 | Engine takes the head byte |
| wr_data | output | 8 | Head transmit byte |
| wr_last | output | 1 | Head byte ends a block write |
| rd_valid | input | 1 | Engine offers a received byte |
| rd_ready | output | 1 | Receive queue has room |
| rd_data | input | 8 | Received byte |
| eng_busy | input | 1 | Engine performing an operation |
| eng_bus_ctrl | input | 1 | Engine owns the bus |
| eng_bus_act | input | 1 | Bus is active |
| eng_miss_ack | input | 1 | Target did not acknowledge |
| prescale | output | PRESCALE_W | Clock divider value to the engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives every queue past full and checks the following. An overflow flag must latch and survive later traffic. A design that dropped the flag, or let the overflowing write replace the head, would show a wrong flag word or a wrong byte order. Reading an empty receive queue must return 0 and lose nothing, so a design that popped anyway would show a missing byte on a later read. Commands with both read and write set must vanish without a trace, and the bench catches a design that queued them or flagged them as overflow. Writes to the masked status address, and prescale writes on a fixed-divider instance, must leave the readable state unchanged.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
    localparam logic [15:0] A_CMD  = 16'h0004;
    localparam logic [15:0] A_DATA = 16'h0008;
    localparam logic [15:0] A_PRE  = 16'h000C;
    localparam logic [15:0] A_MASK = 16'hFF00;
    localparam logic [15:0] A_MIS  = 16'hFF04;
    localparam logic [15:0] A_RIS  = 16'hFF08;
    localparam logic [15:0] A_CLR  = 16'hFF0C;

    localparam int NFLAG    = 12;
    localparam int F_CMDE   = 4;
    localparam int F_CMDF   = 5;
    localparam int F_CMDOVF = 6;
    localparam int F_WRE    = 7;
    localparam int F_WRF    = 8;
    localparam int F_WROVF  = 9;
    localparam int F_RDE    = 10;
    localparam int F_RDF    = 11;

    typedef struct packed {
        logic       stop;
        logic       multi;
        logic       wr;
        logic       rd;
        logic       start;
        logic [6:0] addr;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);
endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata = mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end
endmodule

// File: rtl/i2cfe_irq.sv
module i2cfe_irq
    import i2cfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       live,
    input  logic             cmd_empty,
    input  logic             cmd_full,
    input  logic             wr_empty,
    input  logic             wr_full,
    input  logic             rd_empty,
    input  logic             rd_full,
    input  logic             cmd_ovf_set,
    input  logic             wr_ovf_set,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] wdata,
    output logic [NFLAG-1:0] ris,
    output logic [NFLAG-1:0] mask,
    output logic [NFLAG-1:0] mis,
    output logic             irq
);
    typedef struct packed {
        logic [NFLAG-1:0] mask;
        logic             cmd_ovf;
        logic             wr_ovf;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = wdata;
        if (clr_we) begin
            if (wdata[F_CMDOVF]) st_d.cmd_ovf = 1'b0;
            if (wdata[F_WROVF])  st_d.wr_ovf  = 1'b0;
        end
        if (cmd_ovf_set) st_d.cmd_ovf = 1'b1;
        if (wr_ovf_set)  st_d.wr_ovf  = 1'b1;
    end

    // R10: mask and sticky flags clear on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ris = '0;
        ris[3:0]      = live;
        ris[F_CMDE]   = cmd_empty;
        ris[F_CMDF]   = cmd_full;
        ris[F_CMDOVF] = st_q.cmd_ovf;
        ris[F_WRE]    = wr_empty;
        ris[F_WRF]    = wr_full;
        ris[F_WROVF]  = st_q.wr_ovf;
        ris[F_RDE]    = rd_empty;
        ris[F_RDF]    = rd_full;
    end

    assign mask = st_q.mask;
    assign mis  = ris & st_q.mask;
    assign irq  = |mis;
endmodule

// File: rtl/i2c_apb_frontend.sv
module i2c_apb_frontend
    import i2cfe_pkg::*;
#(
    parameter int CMD_DEPTH        = 32,
    parameter int WR_DEPTH         = 32,
    parameter int RD_DEPTH         = 32,
    parameter int PRESCALE_W       = 16,
    parameter int DEFAULT_PRESCALE = 1,
    parameter int FIXED_PRESCALE   = 0
) (
    input  logic                  pclk,
    input  logic                  presetn,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [15:0]           paddr,
    input  logic [31:0]           pwdata,
    output logic [31:0]           prdata,
    output logic                  pready,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic [11:0]           cmd_data,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [7:0]            wr_data,
    output logic                  wr_last,
    input  logic                  rd_valid,
    output logic                  rd_ready,
    input  logic [7:0]            rd_data,
    input  logic                  eng_busy,
    input  logic                  eng_bus_ctrl,
    input  logic                  eng_bus_act,
    input  logic                  eng_miss_ack,
    output logic [PRESCALE_W-1:0] prescale,
    output logic                  irq
);
    localparam int WQ_W = 9;

    logic wr_en, rd_en;
    logic cmd_legal, cmd_push, cmd_empty, cmd_full;
    logic wq_push, wq_empty, wq_full;
    logic rq_pop, rq_push, rq_empty, rq_full;
    logic pre_we;
    cmd_t cmd_in, cmd_head;
    logic [WQ_W-1:0] wq_head;
    logic [7:0] rq_head;
    logic [NFLAG-1:0] ris, mask, mis;
    logic unused_bits;

    assign pready = 1'b1;  // R1
    assign wr_en  = psel && penable && pwrite;
    assign rd_en  = psel && penable && !pwrite;

    // R2: command entry packing, read+write together rejected
    always_comb begin
        cmd_in.addr  = pwdata[6:0];
        cmd_in.start = pwdata[8];
        cmd_in.rd    = pwdata[9];
        cmd_in.wr    = pwdata[10];
        cmd_in.multi = pwdata[11];
        cmd_in.stop  = pwdata[12];
    end
    assign cmd_legal = !(pwdata[9] && pwdata[10]);
    assign cmd_push  = wr_en && (paddr == A_CMD) && cmd_legal;

    i2cfe_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(pclk), .rst_n(presetn),
        .push(cmd_push), .wdata(cmd_in),
        .pop(cmd_ready), .rdata(cmd_head),
        .empty(cmd_empty), .full(cmd_full)
    );
    assign cmd_valid = !cmd_empty;
    assign cmd_data  = cmd_head;

    // R3: transmit queue
    assign wq_push = wr_en && (paddr == A_DATA);
    i2cfe_fifo #(.W(WQ_W), .DEPTH(WR_DEPTH)) u_wr_q (
        .clk(pclk), .rst_n(presetn),
        .push(wq_push), .wdata({pwdata[9], pwdata[7:0]}),
        .pop(wr_ready), .rdata(wq_head),
        .empty(wq_empty), .full(wq_full)
    );
    assign wr_valid = !wq_empty;
    assign wr_data  = wq_head[7:0];
    assign wr_last  = wq_head[8];

    // R4/R5: receive queue
    assign rq_pop   = rd_en && (paddr == A_DATA);
    assign rd_ready = !rq_full;
    assign rq_push  = rd_valid && !rq_full;
    i2cfe_fifo #(.W(8), .DEPTH(RD_DEPTH)) u_rd_q (
        .clk(pclk), .rst_n(presetn),
        .push(rq_push), .wdata(rd_data),
        .pop(rq_pop), .rdata(rq_head),
        .empty(rq_empty), .full(rq_full)
    );

    // R6/R7/R8: flags, mask and interrupt
    i2cfe_irq u_irq (
        .clk(pclk), .rst_n(presetn),
        .live({eng_miss_ack, eng_bus_act, eng_bus_ctrl, eng_busy}),
        .cmd_empty(cmd_empty), .cmd_full(cmd_full),
        .wr_empty(wq_empty), .wr_full(wq_full),
        .rd_empty(rq_empty), .rd_full(rq_full),
        .cmd_ovf_set(cmd_push && cmd_full),
        .wr_ovf_set(wq_push && wq_full),
        .mask_we(wr_en && (paddr == A_MASK)),
        .clr_we(wr_en && (paddr == A_CLR)),
        .wdata(pwdata[NFLAG-1:0]),
        .ris(ris), .mask(mask), .mis(mis), .irq(irq)
    );

    // R9: divider register, fixed or writable
    assign pre_we = wr_en && (paddr == A_PRE);
    generate
        if (FIXED_PRESCALE != 0) begin : g_pre_fixed
            assign prescale = PRESCALE_W'(DEFAULT_PRESCALE);
            assign unused_bits = ^{pwdata, pre_we};
        end else begin : g_pre_reg
            logic [PRESCALE_W-1:0] pre_d, pre_q;
            always_comb begin
                pre_d = pre_q;
                if (pre_we) pre_d = pwdata[PRESCALE_W-1:0];
            end
            always_ff @(posedge pclk or negedge presetn) begin
                if (!presetn) pre_q <= PRESCALE_W'(DEFAULT_PRESCALE);
                else          pre_q <= pre_d;
            end
            assign prescale = pre_q;
            assign unused_bits = ^pwdata;
        end
    endgenerate

    // R1/R4/R8: read mux
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                A_DATA:  prdata = rq_empty ? 32'd0 : {22'd0, 1'b0, 1'b1, rq_head};
                A_PRE:   prdata = 32'(prescale);
                A_MASK:  prdata = 32'(mask);
                A_MIS:   prdata = 32'(mis);
                A_RIS:   prdata = 32'(ris);
                default: prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/i2cfe_chk.sv
module i2cfe_chk
    import i2cfe_pkg::*;
#(
    parameter int PW    = 16,
    parameter int FIXED = 0,
    parameter int DEF   = 1
) (
    input logic             pclk,
    input logic             presetn,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [15:0]      paddr,
    input logic [31:0]      pwdata,
    input logic [31:0]      prdata,
    input logic             pready,
    input logic [NFLAG-1:0] ris,
    input logic [NFLAG-1:0] mask,
    input logic             cmd_valid,
    input logic             rd_ready,
    input logic [PW-1:0]    prescale
);
    logic acc_wr, acc_rd;
    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;

    // R1
    pready_high_chk: assert property (@(posedge pclk) disable iff (!presetn) pready);

    // R2
    cmd_push_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (acc_wr && paddr == A_CMD && !(pwdata[9] && pwdata[10])) |=> cmd_valid);

    // R4
    empty_read_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (acc_rd && paddr == A_DATA && ris[F_RDE]) |-> (prdata == 32'd0));

    // R5
    rd_ready_chk: assert property (@(posedge pclk) disable iff (!presetn)
        rd_ready == !ris[F_RDF]);

    // R7
    cmd_ovf_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (acc_wr && paddr == A_CMD && !(pwdata[9] && pwdata[10]) && ris[F_CMDF]) |=> ris[F_CMDOVF]);

    // R7
    ovf_sticky_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (ris[F_WROVF] && !(acc_wr && paddr == A_CLR && pwdata[F_WROVF])) |=> ris[F_WROVF]);

    // R8
    mis_read_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (acc_rd && paddr == A_MIS) |-> (prdata == 32'(ris & mask)));

    generate
        if (FIXED != 0) begin : g_fixed
            // R9
            fixed_pre_chk: assert property (@(posedge pclk) disable iff (!presetn)
                prescale == PW'(DEF));
        end
    endgenerate
endmodule

bind i2c_apb_frontend i2cfe_chk #(
    .PW(PRESCALE_W), .FIXED(FIXED_PRESCALE), .DEF(DEFAULT_PRESCALE)
) u_chk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .ris(ris), .mask(mask), .cmd_valid(cmd_valid),
    .rd_ready(rd_ready), .prescale(prescale)
);

// File: tb/i2c_apb_frontend_bench.sv
module i2c_apb_frontend_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic presetn = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [15:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready;
    logic cmd_valid, cmd_ready = 0;
    logic [11:0] cmd_data;
    logic wr_valid, wr_ready = 0, wr_last;
    logic [7:0] wr_data;
    logic rd_valid = 0, rd_ready;
    logic [7:0] rd_data = '0;
    logic [3:0] live = '0;
    logic [15:0] prescale;
    logic irq;

    logic [31:0] f_prdata;
    logic f_pready, f_cmd_valid, f_wr_valid, f_wr_last, f_rd_ready, f_irq;
    logic [11:0] f_cmd_data;
    logic [7:0] f_wr_data;
    logic [15:0] f_prescale;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [11:0] m_cmdq[$];
    logic [8:0]  m_wrq[$];
    logic [7:0]  m_rdq[$];
    bit m_cmd_ovf = 0, m_wr_ovf = 0;
    logic [11:0] m_mask = '0;
    logic [15:0] m_pre = 16'd1;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_apb_frontend #(.CMD_DEPTH(DEPTH), .WR_DEPTH(DEPTH), .RD_DEPTH(DEPTH)) u_i2c_apb_frontend (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .eng_busy(live[0]), .eng_bus_ctrl(live[1]), .eng_bus_act(live[2]), .eng_miss_ack(live[3]),
        .prescale(prescale), .irq(irq)
    );

    i2c_apb_frontend #(.CMD_DEPTH(DEPTH), .WR_DEPTH(DEPTH), .RD_DEPTH(DEPTH),
                       .DEFAULT_PRESCALE(7), .FIXED_PRESCALE(1)) u_fixed (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(f_prdata), .pready(f_pready),
        .cmd_valid(f_cmd_valid), .cmd_ready(1'b0), .cmd_data(f_cmd_data),
        .wr_valid(f_wr_valid), .wr_ready(1'b0), .wr_data(f_wr_data), .wr_last(f_wr_last),
        .rd_valid(1'b0), .rd_ready(f_rd_ready), .rd_data(8'd0),
        .eng_busy(1'b0), .eng_bus_ctrl(1'b0), .eng_bus_act(1'b0), .eng_miss_ack(1'b0),
        .prescale(f_prescale), .irq(f_irq)
    );

    function automatic logic [11:0] exp_ris();
        logic [11:0] r;
        r[3:0] = live;
        r[4]  = (m_cmdq.size() == 0);
        r[5]  = (m_cmdq.size() == DEPTH);
        r[6]  = m_cmd_ovf;
        r[7]  = (m_wrq.size() == 0);
        r[8]  = (m_wrq.size() == DEPTH);
        r[9]  = m_wr_ovf;
        r[10] = (m_rdq.size() == 0);
        r[11] = (m_rdq.size() == DEPTH);
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apb_write(input logic [15:0] a, input logic [31:0] d);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [15:0] a, output logic [31:0] d);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        check("R1", "pready in access", {31'd0, pready}, 32'd1);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic op_cmd(input logic [31:0] v);
        apb_write(16'h0004, v);
        if (!(v[9] && v[10])) begin
            if (m_cmdq.size() < DEPTH) m_cmdq.push_back({v[12:8], v[6:0]});
            else m_cmd_ovf = 1;
        end
    endtask

    task automatic op_wdata(input logic [31:0] v);
        apb_write(16'h0008, v);
        if (m_wrq.size() < DEPTH) m_wrq.push_back({v[9], v[7:0]});
        else m_wr_ovf = 1;
    endtask

    task automatic op_rdata();
        logic [31:0] got, exp;
        apb_read(16'h0008, got);
        exp = 32'd0;
        if (m_rdq.size() > 0) exp = {22'd0, 2'b01, m_rdq.pop_front()};
        check("R4", "data read", got, exp);
    endtask

    task automatic op_eng_cmd();
        #1;
        check("R2", "cmd_valid", {31'd0, cmd_valid}, {31'd0, m_cmdq.size() > 0});
        if (m_cmdq.size() > 0) check("R2", "cmd_data", {20'd0, cmd_data}, {20'd0, m_cmdq[0]});
        cmd_ready = 1;
        @(negedge clk); cmd_ready = 0;
        if (m_cmdq.size() > 0) void'(m_cmdq.pop_front());
    endtask

    task automatic op_eng_wr();
        #1;
        check("R3", "wr_valid", {31'd0, wr_valid}, {31'd0, m_wrq.size() > 0});
        if (m_wrq.size() > 0) check("R3", "wr_last/wr_data", {23'd0, wr_last, wr_data}, {23'd0, m_wrq[0]});
        wr_ready = 1;
        @(negedge clk); wr_ready = 0;
        if (m_wrq.size() > 0) void'(m_wrq.pop_front());
    endtask

    task automatic op_eng_rd(input logic [7:0] b);
        #1;
        check("R5", "rd_ready", {31'd0, rd_ready}, {31'd0, m_rdq.size() < DEPTH});
        rd_valid = 1; rd_data = b;
        @(negedge clk); rd_valid = 0;
        if (m_rdq.size() < DEPTH) m_rdq.push_back(b);
    endtask

    task automatic op_flags();
        logic [31:0] got;
        apb_read(16'hFF08, got);
        check("R6", "raw flags", got, {20'd0, exp_ris()});
        apb_read(16'hFF04, got);
        check("R8", "masked flags", got, {20'd0, exp_ris() & m_mask});
        #1 check("R8", "irq", {31'd0, irq}, {31'd0, |(exp_ris() & m_mask)});
    endtask

    initial begin
        logic [31:0] got;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        presetn = 1;
        @(negedge clk);

        // R10 reset state
        apb_read(16'hFF08, got); check("R10", "raw flags after reset", got, 32'h490);
        apb_read(16'hFF00, got); check("R10", "mask after reset", got, 32'd0);
        check("R9", "prescale reset", {16'd0, prescale}, 32'd1);
        check("R9", "fixed prescale reset", {16'd0, f_prescale}, 32'd7);
        check("R5", "rd_ready after reset", {31'd0, rd_ready}, 32'd1);

        // R1 unmapped and write-only reads
        apb_read(16'h0010, got); check("R1", "unmapped low", got, 32'd0);
        apb_read(16'hFF10, got); check("R1", "unmapped high", got, 32'd0);
        apb_read(16'h0004, got); check("R1", "command read", got, 32'd0);
        apb_read(16'hFF0C, got); check("R1", "clear read", got, 32'd0);

        // R4 empty read
        op_rdata();

        // R2 illegal command is dropped
        op_cmd(32'h0000_1655);
        #1 check("R2", "illegal cmd not queued", {31'd0, cmd_valid}, 32'd0);
        op_flags();

        // R7 command overflow and clear
        for (int i = 0; i < DEPTH + 1; i++) op_cmd(32'h0000_0100 | i);
        op_flags();
        op_eng_cmd();
        op_cmd(32'h0000_1000);
        op_flags();
        apb_write(16'hFF0C, 32'h40);
        m_cmd_ovf = 0;
        op_flags();
        for (int i = 0; i < DEPTH; i++) op_eng_cmd();

        // R9 prescale
        apb_write(16'h000C, 32'hABCD_1234);
        m_pre = 16'h1234;
        apb_read(16'h000C, got); check("R9", "prescale readback", got, 32'h1234);
        check("R9", "fixed prescale unchanged", {16'd0, f_prescale}, 32'd7);

        // R8 mask, MIS write ignored
        apb_write(16'hFF00, 32'hFFF); m_mask = 12'hFFF;
        apb_write(16'hFF04, 32'h0);
        apb_read(16'hFF00, got); check("R8", "mask after MIS write", got, 32'hFFF);
        op_flags();

        // R3 write queue with last marker, and overflow
        for (int i = 0; i < DEPTH + 2; i++) op_wdata({22'd0, i[0], 1'b0, 8'hA0 + i[7:0]});
        op_flags();
        for (int i = 0; i < DEPTH + 1; i++) op_eng_wr();
        apb_write(16'hFF0C, 32'h200); m_wr_ovf = 0;
        op_flags();

        // R5 receive queue fill, R4 ordered pops
        for (int i = 0; i < DEPTH + 1; i++) op_eng_rd(8'h30 + i[7:0]);
        op_flags();
        for (int i = 0; i < DEPTH + 1; i++) op_rdata();

        // random mix
        for (int n = 0; n < 800; n++) begin
            int unsigned sel;
            logic [31:0] v;
            sel = $urandom_range(0, 11);
            v = $urandom;
            case (sel)
                0, 1: op_cmd(($urandom_range(0, 5) == 0) ? (v | 32'h600) : v);
                2, 3: op_wdata(v);
                4:    op_rdata();
                5:    op_eng_cmd();
                6:    op_eng_wr();
                7:    op_eng_rd(v[7:0]);
                8:    begin apb_write(16'hFF00, v); m_mask = v[11:0]; end
                9:    begin
                          apb_write(16'hFF0C, v);
                          if (v[6]) m_cmd_ovf = 0;
                          if (v[9]) m_wr_ovf = 0;
                      end
                10:   begin live = v[3:0]; @(negedge clk); end
                default: op_flags();
            endcase
        end
        op_flags();
        apb_read(16'h000C, got); check("R9", "prescale kept", got, {16'd0, m_pre});

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule